// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `W` bits each and returns a `2W`-bit signed product. It uses radix-2 Booth recoding. The low bit of the multiplier register and one extra appended bit are examined as a pair. That pair chooses whether the multiplicand is subtracted from the accumulator, added to it, or left out. Every clock cycle does one add/subtract/skip decision and one arithmetic right shift of the chain {accumulator, multiplier register, appended bit}.

A caller presents both operands together with a one-cycle `start` while the block is idle. `busy` then stays high for exactly `W` cycles. In the cycle after the last step, `done` is high for a single cycle and `product` carries the result. The result stays on `product` until the next accepted `start`. While the block is busy, `start` has no effect. The accumulator is one bit wider than the operands, so that the most negative operand pair still gives the exact result.

Top module: `booth_mult`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 captures `mcand` and `mplier`, and `busy` is 1 on the following cycle.
- R3: `product` is the signed two's-complement value of `mcand` × `mplier`. The upper half is the sign-carrying high word and bit 2W-1 is the sign. Each step subtracts the multiplicand when the pair (multiplier LSB, appended bit) is 10, adds it when the pair is 01, and skips the add/subtract when the pair is 00 or 11.
- R4: `busy` stays high for exactly `W` cycles after the accepting edge. `done` is high only in the single cycle in which `busy` has just fallen.
- R5: The most negative multiplicand times the most negative multiplier gives +2^(2W-2), for example 16'h4000 when W = 8, with no overflow.
- R6: A `start` asserted while `busy` is 1 is ignored. The running operation finishes with its original operands and no extra result is produced.
- R7: While idle and with `start` low, `product` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Signed product {accumulator, multiplier register} |

## Verification
The bench first covers the sign extremes: the most negative value times itself, times +1 and times the most positive value, then -1 × -1 and zero. A design whose accumulator is only `W` bits wide returns a wrong sign on the most-negative-squared case. A design that shifts logically instead of arithmetically corrupts every negative partial product. Random operand pairs exercise all four recoding pairs; a swapped add/subtract decode shows up as the wrong sign or wrong magnitude. Re-asserting `start` mid-operation checks that a design accepting it would restart, return the second result, or raise `done` twice. An off-by-one counter moves `done` off the W-cycle slot.

// File: rtl/booth_mult.sv
module booth_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    ac;
  logic [W-1:0]  br;
  logic [W-1:0]  qr;
  logic          qx;
  logic [CW-1:0] cnt;
  logic [W:0]    sum;

  wire [W:0] br_x = {br[W-1], br};
  wire       last = (cnt == CW'(1));

  always_comb begin
    case ({qr[0], qx})
      2'b10:   sum = ac - br_x;
      2'b01:   sum = ac + br_x;
      default: sum = ac;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac   <= '0;
      br   <= '0;
      qr   <= '0;
      qx   <= 1'b0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        ac  <= {sum[W], sum[W:1]};
        qr  <= {sum[0], qr[W-1:1]};
        qx  <= qr[0];
        cnt <= cnt - CW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        ac   <= '0;
        br   <= mcand;
        qr   <= mplier;
        qx   <= 1'b0;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end
    end
  end

  assign product = {ac[W-1:0], qr};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ac[W] == ac[W-1]); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && cnt == $past(cnt) - CW'(1))); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(br)); // R6
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product)); // R7
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R2
endmodule

// File: tb/booth_mult_tb.sv
module booth_mult_tb;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [2*W-1:0] expq[$];

  booth_mult #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] ea, eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return ea * eb;
  endfunction

  // monitor: pops expected products as results appear (R3)
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6 unexpected done", product, '0);
      end else begin
        logic [2*W-1:0] e;
        e = expq.pop_front();
        check(product === e, "R3 product", product, e);
      end
    end
  end

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    logic [2*W-1:0] held;
    while (busy) @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    expq.push_back(ref_mul(a, b));
    @(negedge clk);
    check(busy === 1'b1, "R2 busy after start", {15'd0, busy}, 16'd1);
    if (poke) begin
      start = 1'b1; mcand = ~a; mplier = b + 1'b1;
    end else start = 1'b0;
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      if (i == 3) start = 1'b0;
      check(done === 1'b0 && busy === 1'b1, "R4 busy window", {14'd0, busy, done}, 16'd2);
    end
    start = 1'b0;
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R4 done after W cycles", {14'd0, busy, done}, 16'd1);
    held = product;
    repeat (3) begin
      @(negedge clk);
      check(done === 1'b0, "R4 single pulse", {15'd0, done}, 16'd0);
      check(product === held, "R7 product held", product, held);
    end
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(busy === 1'b0, "R1 busy reset", {15'd0, busy}, 16'd0);
    check(done === 1'b0, "R1 done reset", {15'd0, done}, 16'd0);
    check(product === '0, "R1 product reset", product, '0);
    rst_n = 1'b1;
    @(negedge clk);
    run(8'h80, 8'h80, 1'b0);   // R5
    check(product === 16'h4000, "R5 most negative squared", product, 16'h4000);
    run(8'h80, 8'h7F, 1'b0);
    run(8'h7F, 8'h80, 1'b0);
    run(8'h80, 8'h01, 1'b0);
    run(8'h7F, 8'h7F, 1'b0);
    run(8'hFF, 8'hFF, 1'b0);
    run(8'h00, 8'h9C, 1'b0);
    run(8'h05, 8'hFD, 1'b0);
    run(8'h55, 8'hAA, 1'b0);   // alternating pairs 01/10
    run(8'h33, 8'hF0, 1'b0);   // 00/11 runs
    run(8'h6B, 8'h2C, 1'b1);   // R6 start while busy
    for (int k = 0; k < 40; k++) run(W'($urandom), W'($urandom), k % 5 == 0);
    repeat (W + 3) @(negedge clk);
    check(expq.size() == 0, "R6 queue drained", 16'(expq.size()), 16'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule